// File: doc/BRIEF.md
# Spread-Spectrum Sweep Profile Generator

This block lives in the reference clock domain of a spread-spectrum clock synthesizer. It produces a signed frequency-offset code that a current-output DAC turns into a control current for the PLL oscillator. The oscillator frequency therefore follows a linear triangle around, or below, its nominal value. The code is in units of 0.01 %. Two strobes mark the highest and lowest points of each sweep, so that a neighbouring block can line up with the modulation.

The length of each sweep is counted in reference clocks and depends on a 2-bit band select. Successive sweeps step through a repeating list of lengths: short, typical, long, typical. The mean length is therefore exactly the typical count, while the sweep rate still varies from cycle to cycle. A 2-bit profile select chooses one of four shapes: two centred on nominal and two that lie wholly below it.

Band and profile changes are applied only at the start of the next sweep. Dropping the enable or asserting the active-low power-down parks the generator at zero offset. When the generator resumes, it starts a fresh sweep at the short end of the length list.

Top module: `ssm_profile_gen`

## Requirements
- R1: While `rst` is high the offset code reads 0 and both strobes are low, whatever the other inputs are.
- R2: Sweep lengths in clocks follow the band select (0:120, 1:200, 2:240, 3:400 clocks per unit) multiplied in turn by 16, 19, 22, 19, then repeating. The length of each sweep is the number of clocks between successive sweep starts.
- R3: Centre profiles (prof_sel 0 and 1) start at 0, rise linearly to +A at one quarter of the sweep, fall through 0 at the half to -A at three quarters, and return to 0.
- R4: Down profiles (prof_sel 2 and 3) never go above 0. They start at 0, fall to -A at the half sweep, and climb back.
- R5: The amplitude A in 0.01 % units is 50 for prof_sel 0, 150 for 1, 100 for 2 and 300 for 3.
- R6: When `mod_en` is sampled low, the next output is 0 with both strobes low, and it stays so while `mod_en` is low.
- R7: When `pd_n` is sampled low, the next output is 0 with both strobes low. On release, the length list restarts at the short (x16) entry.
- R8: A band or profile change made during a sweep leaves that sweep unchanged and applies from the next sweep start.
- R9: At clock t of a sweep with segment length L (a quarter of the sweep for centre, a half for down), the magnitude is floor(A*k/L) on rising-magnitude segments and A - floor(A*k/L) on falling ones, where k = t mod L. Consecutive running codes differ by at most 1.
- R10: `peak_stb` marks the highest point of a sweep: +A for centre profiles, or the 0 at the sweep start for down profiles. `trough_stb` marks -A. The strobes are never high together. Each strobe appears in the same cycle as the code it marks.
- R11: The first output after the generator starts is the 0 of sweep clock t = 0. The code then advances by one sweep clock per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| band_sel | input | 2 | Input-frequency band, selects sweep length |
| prof_sel | input | 2 | Spread profile: 0/1 centre, 2/3 down |
| mod_en | input | 1 | Modulation enable, high to sweep |
| pd_n | input | 1 | Active-low power-down |
| ofs_code | output | 12 | Signed offset code, 0.01 % per LSB |
| peak_stb | output | 1 | High in the cycle the code is at its sweep maximum |
| trough_stb | output | 1 | High in the cycle the code is at its sweep minimum |

## Verification
The hardest case to reach is a band or profile change that lands in the middle of a sweep. The new setting has to stay invisible until the wrap, and then take effect with the correct entry of the length list. The bench reaches it directly: it changes the selects right after a strobe, then reads the next trough from the old profile and the one after from the new. Random phases then change band, profile, enable and power-down at arbitrary points of a sweep, so that boundary crossings of all four lengths are covered. An independent division-based model predicts every code and strobe in these phases.

// File: rtl/ssm_pkg.sv
package ssm_pkg;
  localparam int PER_W = 14;
  localparam int SEG_W = PER_W;
  localparam int AMP_W = 9;

  typedef enum logic [1:0] {
    SLOT_MIN   = 2'd0,
    SLOT_TYP_A = 2'd1,
    SLOT_MAX   = 2'd2,
    SLOT_TYP_B = 2'd3
  } len_slot_e;

  typedef struct packed {
    logic [SEG_W-1:0] seg_len;
    logic [AMP_W-1:0] amp;
    logic             center;
  } sweep_cfg_t;
endpackage

// File: rtl/ssm_cfg_latch.sv
module ssm_cfg_latch
  import ssm_pkg::*;
#(
  parameter int UNIT0    = 120,
  parameter int UNIT1    = 200,
  parameter int UNIT2    = 240,
  parameter int UNIT3    = 400,
  parameter int MUL_MIN  = 16,
  parameter int MUL_TYP  = 19,
  parameter int MUL_MAX  = 22,
  parameter int AMP_C_LO = 50,
  parameter int AMP_C_HI = 150,
  parameter int AMP_D_LO = 100,
  parameter int AMP_D_HI = 300
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       clr,
  input  logic       load,
  input  logic [1:0] band_sel,
  input  logic [1:0] prof_sel,
  output sweep_cfg_t cfg
);
  len_slot_e        slot_q;
  logic [PER_W-1:0] unit_c;
  logic [PER_W-1:0] mul_c;
  logic [PER_W-1:0] per_c;
  logic [SEG_W-1:0] seg_c;
  logic [AMP_W-1:0] amp_c;
  logic             ctr_c;

  always_comb begin
    case (band_sel)
      2'd0:    unit_c = PER_W'(UNIT0);
      2'd1:    unit_c = PER_W'(UNIT1);
      2'd2:    unit_c = PER_W'(UNIT2);
      default: unit_c = PER_W'(UNIT3);
    endcase
    case (slot_q)
      SLOT_MIN: mul_c = PER_W'(MUL_MIN);
      SLOT_MAX: mul_c = PER_W'(MUL_MAX);
      default:  mul_c = PER_W'(MUL_TYP);
    endcase
    per_c = unit_c * mul_c;
    ctr_c = ~prof_sel[1];
    case (prof_sel)
      2'd0:    amp_c = AMP_W'(AMP_C_LO);
      2'd1:    amp_c = AMP_W'(AMP_C_HI);
      2'd2:    amp_c = AMP_W'(AMP_D_LO);
      default: amp_c = AMP_W'(AMP_D_HI);
    endcase
    seg_c = ctr_c ? (per_c >> 2) : (per_c >> 1);
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      slot_q <= SLOT_MIN;
    end else if (load) begin
      slot_q <= len_slot_e'(slot_q + 2'd1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg <= '0;
    end else if (load) begin
      cfg.seg_len <= seg_c;
      cfg.amp     <= amp_c;
      cfg.center  <= ctr_c;
    end
  end
endmodule

// File: rtl/ssm_ramp.sv
module ssm_ramp
  import ssm_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             adv,
  input  sweep_cfg_t       cfg,
  output logic [AMP_W-1:0] mag,
  output logic             neg,
  output logic             at_peak,
  output logic             at_trough,
  output logic             wrap
);
  logic [1:0]       seg_q;
  logic [SEG_W-1:0] k_q;
  logic [SEG_W-1:0] acc_q;
  logic [AMP_W-1:0] q_q;
  logic [SEG_W:0]   acc_sum;
  logic             seg_end;
  logic [1:0]       last_seg;
  logic             k_zero;

  assign acc_sum  = {1'b0, acc_q} + (SEG_W+1)'(cfg.amp);
  assign seg_end  = (k_q == cfg.seg_len - SEG_W'(1));
  assign last_seg = cfg.center ? 2'd3 : 2'd1;
  assign wrap     = seg_end && (seg_q == last_seg);
  assign k_zero   = (k_q == '0);

  always_ff @(posedge clk) begin
    if (rst || start) begin
      seg_q <= 2'd0;
      k_q   <= '0;
      acc_q <= '0;
      q_q   <= '0;
    end else if (adv) begin
      if (seg_end) begin
        seg_q <= seg_q + 2'd1;
        k_q   <= '0;
        acc_q <= '0;
        q_q   <= '0;
      end else begin
        k_q <= k_q + SEG_W'(1);
        if (acc_sum >= {1'b0, cfg.seg_len}) begin
          acc_q <= SEG_W'(acc_sum - {1'b0, cfg.seg_len});
          q_q   <= q_q + AMP_W'(1);
        end else begin
          acc_q <= SEG_W'(acc_sum);
        end
      end
    end
  end

  always_comb begin
    mag       = seg_q[0] ? (cfg.amp - q_q) : q_q;
    neg       = cfg.center ? seg_q[1] : 1'b1;
    at_peak   = k_zero && (cfg.center ? (seg_q == 2'd1) : (seg_q == 2'd0));
    at_trough = k_zero && (cfg.center ? (seg_q == 2'd3) : (seg_q == 2'd1));
  end
endmodule

// File: rtl/ssm_profile_gen.sv
module ssm_profile_gen
  import ssm_pkg::*;
#(
  parameter int OFS_W    = 12,
  parameter int UNIT0    = 120,
  parameter int UNIT1    = 200,
  parameter int UNIT2    = 240,
  parameter int UNIT3    = 400,
  parameter int MUL_MIN  = 16,
  parameter int MUL_TYP  = 19,
  parameter int MUL_MAX  = 22,
  parameter int AMP_C_LO = 50,
  parameter int AMP_C_HI = 150,
  parameter int AMP_D_LO = 100,
  parameter int AMP_D_HI = 300
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [1:0]              band_sel,
  input  logic [1:0]              prof_sel,
  input  logic                    mod_en,
  input  logic                    pd_n,
  output logic signed [OFS_W-1:0] ofs_code,
  output logic                    peak_stb,
  output logic                    trough_stb
);
  sweep_cfg_t       cfg;
  logic             run;
  logic             active_q;
  logic             load;
  logic             adv;
  logic             wrap;
  logic [AMP_W-1:0] mag;
  logic             neg;
  logic             at_peak;
  logic             at_trough;
  logic [OFS_W-1:0] mag_ext;

  assign run     = pd_n & mod_en;
  assign load    = run && (!active_q || wrap);
  assign adv     = run && active_q && !wrap;
  assign mag_ext = OFS_W'(mag);

  ssm_cfg_latch #(
    .UNIT0(UNIT0), .UNIT1(UNIT1), .UNIT2(UNIT2), .UNIT3(UNIT3),
    .MUL_MIN(MUL_MIN), .MUL_TYP(MUL_TYP), .MUL_MAX(MUL_MAX),
    .AMP_C_LO(AMP_C_LO), .AMP_C_HI(AMP_C_HI),
    .AMP_D_LO(AMP_D_LO), .AMP_D_HI(AMP_D_HI)
  ) u_cfg (
    .clk      (clk),
    .rst      (rst),
    .clr      (!run),
    .load     (load),
    .band_sel (band_sel),
    .prof_sel (prof_sel),
    .cfg      (cfg)
  );

  ssm_ramp u_ramp (
    .clk       (clk),
    .rst       (rst),
    .start     (load),
    .adv       (adv),
    .cfg       (cfg),
    .mag       (mag),
    .neg       (neg),
    .at_peak   (at_peak),
    .at_trough (at_trough),
    .wrap      (wrap)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q   <= 1'b0;
      ofs_code   <= '0;
      peak_stb   <= 1'b0;
      trough_stb <= 1'b0;
    end else begin
      active_q <= run;
      if (run && active_q) begin
        ofs_code   <= neg ? -mag_ext : mag_ext;
        peak_stb   <= at_peak;
        trough_stb <= at_trough;
      end else begin
        ofs_code   <= '0;
        peak_stb   <= 1'b0;
        trough_stb <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/ssm_profile_chk.sv
module ssm_profile_chk #(
  parameter int OFS_W    = 12,
  parameter int AMP_C_LO = 50,
  parameter int AMP_C_HI = 150,
  parameter int AMP_D_LO = 100,
  parameter int AMP_D_HI = 300
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    mod_en,
  input logic                    pd_n,
  input logic signed [OFS_W-1:0] ofs_code,
  input logic                    peak_stb,
  input logic                    trough_stb
);
  logic                    run;
  logic signed [OFS_W-1:0] prev_ofs;
  logic signed [OFS_W:0]   step_d;

  assign run    = pd_n & mod_en;
  assign step_d = {ofs_code[OFS_W-1], ofs_code} - {prev_ofs[OFS_W-1], prev_ofs};

  always_ff @(posedge clk) begin
    if (rst) prev_ofs <= '0;
    else     prev_ofs <= ofs_code;
  end

  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (ofs_code == 0 && !peak_stb && !trough_stb)); // R1

  AST_RANGE_BOUND: assert property (@(posedge clk) disable iff (rst)
    (ofs_code <= AMP_C_HI && ofs_code >= -AMP_D_HI)); // R3

  AST_DISABLE_ZERO: assert property (@(posedge clk) disable iff (rst)
    !mod_en |=> (ofs_code == 0 && !peak_stb && !trough_stb)); // R6

  AST_PWRDN_ZERO: assert property (@(posedge clk) disable iff (rst)
    !pd_n |=> (ofs_code == 0 && !peak_stb && !trough_stb)); // R7

  AST_STEP_ONE: assert property (@(posedge clk) disable iff (rst)
    (run && $past(run)) |=> (step_d >= -1 && step_d <= 1)); // R9

  AST_PEAK_LEVEL: assert property (@(posedge clk) disable iff (rst)
    peak_stb |-> (ofs_code == 0 || ofs_code == AMP_C_LO || ofs_code == AMP_C_HI)); // R10

  AST_TROUGH_LEVEL: assert property (@(posedge clk) disable iff (rst)
    trough_stb |-> (ofs_code == -AMP_C_LO || ofs_code == -AMP_C_HI ||
                    ofs_code == -AMP_D_LO || ofs_code == -AMP_D_HI)); // R10

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(peak_stb && trough_stb)); // R10
endmodule

bind ssm_profile_gen ssm_profile_chk #(
  .OFS_W(OFS_W), .AMP_C_LO(AMP_C_LO), .AMP_C_HI(AMP_C_HI),
  .AMP_D_LO(AMP_D_LO), .AMP_D_HI(AMP_D_HI)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .mod_en     (mod_en),
  .pd_n       (pd_n),
  .ofs_code   (ofs_code),
  .peak_stb   (peak_stb),
  .trough_stb (trough_stb)
);

// File: tb/tb_ssm_profile_gen.sv
`timescale 1ns/1ps
module tb_ssm_profile_gen;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic              rst = 1'b1;
  logic [1:0]        band = 2'd0;
  logic [1:0]        prof = 2'd3;
  logic              en = 1'b1;
  logic              pdn = 1'b1;
  logic signed [11:0] ofs;
  logic              pk;
  logic              tr;

  ssm_profile_gen dut (
    .clk(clk), .rst(rst), .band_sel(band), .prof_sel(prof),
    .mod_en(en), .pd_n(pdn), .ofs_code(ofs), .peak_stb(pk), .trough_stb(tr)
  );

  int total = 0, bad = 0, cyc = 0, last_pk = 0, mn = 0, mx = 0;
  bit m_act = 0, m_c = 0;
  int m_t = 0, m_P = 1, m_L = 1, m_A = 0, m_slot = 0;
  int e_ofs = 0;
  bit e_pk = 0, e_tr = 0;

  function automatic int unit_of(input int b);
    case (b) 0: return 120; 1: return 200; 2: return 240; default: return 400; endcase
  endfunction
  function automatic int mul_of(input int s);
    case (s) 0: return 16; 2: return 22; default: return 19; endcase
  endfunction
  function automatic int amp_of(input int p);
    case (p) 0: return 50; 1: return 150; 2: return 100; default: return 300; endcase
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // reference from the requirements: R2 lengths, R3/R4 shapes, R5 amplitudes, R9 floor law, R11 start
  task automatic model_edge();
    bit run;
    int s, k, base, mag;
    run = pdn && en;
    if (!rst && run && m_act) begin
      s    = m_t / m_L;
      k    = m_t % m_L;
      base = (m_A * k) / m_L;
      mag  = (s % 2 == 1) ? m_A - base : base;
      e_ofs = (m_c ? (s >= 2) : 1'b1) ? -mag : mag;
      e_pk  = (k == 0) && (m_c ? s == 1 : s == 0);
      e_tr  = (k == 0) && (m_c ? s == 3 : s == 1);
    end else begin
      e_ofs = 0; e_pk = 0; e_tr = 0;
    end
    if (rst || !run) begin
      m_act = 0; m_slot = 0;
    end else if (!m_act || m_t == m_P - 1) begin
      m_P = unit_of(int'(band)) * mul_of(m_slot);
      m_c = (prof < 2);
      m_A = amp_of(int'(prof));
      m_L = m_c ? m_P / 4 : m_P / 2;
      m_slot = (m_slot + 1) % 4;
      m_t = 0;
      m_act = 1;
    end else begin
      m_t++;
    end
  endtask

  task automatic tick();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    cyc++;
    chk(int'(ofs) == e_ofs, "R9 code", int'(ofs), e_ofs);
    chk(pk == e_pk, "R10 peak_stb", int'(pk), int'(e_pk));
    chk(tr == e_tr, "R10 trough_stb", int'(tr), int'(e_tr));
    if (int'(ofs) < mn) mn = int'(ofs);
    if (int'(ofs) > mx) mx = int'(ofs);
  endtask

  task automatic wait_strobe(input bit want_peak, output int gap, output int val);
    bit seen = 0;
    gap = 0; val = 0;
    for (int i = 0; i < 20000; i++) begin
      tick();
      if (want_peak ? pk : tr) begin
        val = int'(ofs);
        if (want_peak) begin
          gap = cyc - last_pk;
          last_pk = cyc;
        end
        seen = 1;
        break;
      end
    end
    if (!seen) chk(0, "R10 strobe missing", 0, 1);
  endtask

  initial begin
    int g, v;
    void'($urandom(32'h5eed_0c1c));
    // R1: reset dominates an enabled configuration
    repeat (5) tick();
    chk(ofs == 0, "R1 code in reset", int'(ofs), 0);
    chk(!pk && !tr, "R1 strobes in reset", int'(pk) + int'(tr), 0);
    rst = 1'b0;

    // R11: first output after start is sweep clock 0, a down-profile peak
    tick();
    tick();
    chk(pk == 1 && ofs == 0, "R11 first output", int'(ofs), 0);
    last_pk = cyc;
    mn = 0; mx = 0;
    // R2: band 0 lengths min, typ, max, typ
    for (int i = 0; i < 4; i++) begin
      wait_strobe(1'b1, g, v);
      chk(g == unit_of(0) * mul_of(i), "R2 sweep length", g, unit_of(0) * mul_of(i));
    end
    chk(mx == 0, "R4 down never above zero", mx, 0);
    chk(mn == -300, "R4 down reaches -A", mn, -300);

    // R8: change mid sweep, old trough first
    band = 2'd1; prof = 2'd1;
    wait_strobe(1'b0, g, v);
    chk(v == -300, "R8 old profile kept", v, -300);
    wait_strobe(1'b1, g, v);
    chk(v == 150, "R3 centre peak", v, 150);
    wait_strobe(1'b0, g, v);
    chk(v == -150, "R3 centre trough", v, -150);

    // R5: the other two amplitudes
    prof = 2'd0;
    wait_strobe(1'b1, g, v);
    chk(v == 50, "R5 prof 0 amplitude", v, 50);
    prof = 2'd2;
    wait_strobe(1'b0, g, v);
    chk(v == -50, "R8 prof 0 still in force", v, -50);
    wait_strobe(1'b0, g, v);
    chk(v == -100, "R5 prof 2 amplitude", v, -100);

    // R6: enable low
    en = 1'b0;
    tick();
    chk(ofs == 0 && !pk && !tr, "R6 disabled output", int'(ofs), 0);
    repeat (20) tick();
    chk(ofs == 0, "R6 stays zero", int'(ofs), 0);
    en = 1'b1;
    repeat (30) tick();

    // R7: power-down, then list restarts at the short length
    pdn = 1'b0;
    tick();
    chk(ofs == 0 && !pk && !tr, "R7 power-down output", int'(ofs), 0);
    repeat (10) tick();
    pdn = 1'b1;
    wait_strobe(1'b1, g, v);
    wait_strobe(1'b1, g, v);
    chk(g == 16 * 200, "R7 restart at short length", g, 16 * 200);

    // random phases checked against the model
    for (int c = 0; c < 25; c++) begin
      int n;
      band = 2'($urandom_range(0, 3));
      prof = 2'($urandom_range(0, 3));
      en   = ($urandom_range(0, 7) != 0);
      pdn  = ($urandom_range(0, 7) != 0);
      rst  = ($urandom_range(0, 15) == 0);
      n    = $urandom_range(200, 3000);
      tick();
      rst = 1'b0;
      repeat (n) tick();
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #950000;
    total++;
    bad++;
    $display("FAIL watchdog all requirements actual=%0d expected=%0d", cyc, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule